// File: doc/BRIEF.md
# SDRAM Closed-Page Access Sequencer

This block carries out one read or one write at a time on an SDRAM that has already been initialized. A user request gives a bank, a row, a column and a direction. The block opens the row and waits out the row-to-column delay. It then issues the column command and moves a fixed-length burst. Last, it closes the row again and waits for the precharge time before it takes the next request. Every access therefore finds the bank closed, and timing does not depend on earlier traffic.

A free-running interval counter raises a refresh demand. The sequencer serves that demand only between accesses, and ahead of any request that is waiting. A quiet recovery window follows each refresh. Write data is taken from the user in the cycles flagged by `wr_beat` and passed straight to the data pins. Read words come back registered, each one flagged by a one-cycle `rd_valid` pulse.

Top module: `sdr_access_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle and no refresh is pending. A request accepted at a clock edge puts ACTIVE ({cs_n,ras_n,cas_n,we_n} = 0011) on the command pins in the following cycle, with the request's bank on `sd_ba` and its row on `sd_addr`.
- R2: READ (0101) or WRITE (0100) appears exactly T_RCD cycles after ACTIVE, with the same bank. `sd_addr` carries the column zero-extended, and bit 10 is low, so there is no auto-precharge.
- R3: For a READ in cycle R, the word on `sd_dq_in` in cycle R+CAS_LAT+k (k = 0..BURST_LEN-1) appears on `rd_data` in cycle R+CAS_LAT+1+k, with `rd_valid` high for exactly those cycles.
- R4: For a WRITE in cycle W, `sd_dq_oe` and `wr_beat` are high in cycles W..W+BURST_LEN-1 and only then. In each of those cycles `sd_dq_out` equals `wr_data`, so the user's words go out in order.
- R5: After a write, PRECHARGE (0010, bit 10 low, same bank) appears T_WR+1 cycles after the last data cycle. This leaves T_WR full recovery cycles between them.
- R6: After a read, PRECHARGE appears BURST_LEN cycles after the READ command.
- R7: ACTIVE or AUTO-REFRESH comes at least T_RP+1 cycles after a PRECHARGE.
- R8: A refresh demand is raised every REF_INTERVAL cycles, counted from reset. On an idle sequencer it produces AUTO-REFRESH (0001) in the next cycle, so the first one is due REF_INTERVAL+1 cycles after reset.
- R9: A pending refresh takes priority over a waiting request, and `req_ready` stays low until it is served. T_RFC NOP cycles (0111) follow the refresh, and a request waiting through it gets ACTIVE T_RFC+1 cycles after the refresh.
- R10: During and right after reset, the command pins show NOP, `sd_dq_oe` and `rd_valid` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken at this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Bank of the access |
| req_row | input | 13 | Row of the access |
| req_col | input | COL_W | Starting column |
| wr_data | input | DQ_W | Write word for the current beat |
| wr_beat | output | 1 | `wr_data` is consumed this cycle |
| rd_data | output | DQ_W | Captured read word |
| rd_valid | output | 1 | `rd_data` holds a new word |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Row / column address |
| sd_dq_out | output | DQ_W | Data driven toward the memory |
| sd_dq_oe | output | 1 | Output enable for `sd_dq_out` |
| sd_dq_in | input | DQ_W | Data returned by the memory |

## Verification
Every deadline is counted from the edge that accepts a request, called cycle a:
- ACTIVE is due in cycle a.
- The column command is due in cycle a+T_RCD.
- Write beats are due in cycles a+T_RCD+k.
- Read words are due on `rd_valid` in cycles a+T_RCD+CAS_LAT+1+k.
- PRECHARGE is due BURST_LEN cycles after a READ, or T_WR+1 cycles after the last write beat.

The driver records cycle a for each request and queues every expected event with its absolute cycle number. The monitor samples one nanosecond after each falling edge and compares both value and cycle. Refresh deadlines are fixed multiples of REF_INTERVAL plus one, and the priority case puts a request on the port exactly when a refresh demand appears.

// File: rtl/sdr_seq_pkg.sv
`timescale 1ns/1ps
package sdr_seq_pkg;
  localparam int unsigned SDR_ADDR_W = 13;
  localparam int unsigned SDR_BA_W   = 2;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010,
    CMD_REF = 4'b0001
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ACT_WAIT, ST_BURST, ST_WR_REC, ST_PRE_WAIT, ST_REF_WAIT
  } seq_state_e;

  // Down-counter load for a phase that lasts n cycles (n >= 1).
  function automatic int unsigned phase_load(input int unsigned n);
    return (n > 0) ? n - 1 : 0;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Column placed on the address pins with bit 10 forced low (no auto-precharge).
  function automatic logic [SDR_ADDR_W-1:0] col_to_addr(input logic [SDR_ADDR_W-1:0] col);
    logic [SDR_ADDR_W-1:0] a;
    a     = col;
    a[10] = 1'b0;
    return a;
  endfunction
endpackage

// File: rtl/sdr_refresh_timer.sv
`timescale 1ns/1ps
module sdr_refresh_timer #(
  parameter int unsigned INTERVAL = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic pending
);
  localparam int unsigned CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == CW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap)     pending <= 1'b1;
      else if (ack) pending <= 1'b0;
    end
  end

  AST_PEND_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> pending); // R8
  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !wrap) |=> !pending); // R8
endmodule

// File: rtl/sdr_read_capture.sv
`timescale 1ns/1ps
module sdr_read_capture #(
  parameter int unsigned DQ_W    = 16,
  parameter int unsigned CAS_LAT = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_slot,
  input  logic [DQ_W-1:0] dq_in,
  output logic [DQ_W-1:0] rd_data,
  output logic            rd_valid
);
  // Delay line: stage j is high j cycles after a read burst slot.
  logic [CAS_LAT:1] slot_dly;

  always_ff @(posedge clk) begin
    if (!rst_n) slot_dly[1] <= 1'b0;
    else        slot_dly[1] <= rd_slot;
  end

  for (genvar j = 2; j <= CAS_LAT; j++) begin : g_dly
    always_ff @(posedge clk) begin
      if (!rst_n) slot_dly[j] <= 1'b0;
      else        slot_dly[j] <= slot_dly[j-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= slot_dly[CAS_LAT];
      if (slot_dly[CAS_LAT]) rd_data <= dq_in;
    end
  end

  AST_RDV_FOLLOWS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    slot_dly[CAS_LAT] |=> rd_valid); // R3
endmodule

// File: rtl/sdr_access_seq.sv
`timescale 1ns/1ps
module sdr_access_seq
  import sdr_seq_pkg::*;
#(
  parameter int unsigned DQ_W         = 16,
  parameter int unsigned COL_W        = 9,
  parameter int unsigned BURST_LEN    = 4,
  parameter int unsigned T_RCD        = 2,
  parameter int unsigned CAS_LAT      = 3,
  parameter int unsigned T_WR         = 2,
  parameter int unsigned T_RP         = 2,
  parameter int unsigned T_RFC        = 7,
  parameter int unsigned REF_INTERVAL = 780
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [SDR_BA_W-1:0]   req_bank,
  input  logic [SDR_ADDR_W-1:0] req_row,
  input  logic [COL_W-1:0]      req_col,
  input  logic [DQ_W-1:0]       wr_data,
  output logic                  wr_beat,
  output logic [DQ_W-1:0]       rd_data,
  output logic                  rd_valid,
  output logic                  sd_cs_n,
  output logic                  sd_ras_n,
  output logic                  sd_cas_n,
  output logic                  sd_we_n,
  output logic [SDR_BA_W-1:0]   sd_ba,
  output logic [SDR_ADDR_W-1:0] sd_addr,
  output logic [DQ_W-1:0]       sd_dq_out,
  output logic                  sd_dq_oe,
  input  logic [DQ_W-1:0]       sd_dq_in
);
  localparam int unsigned CNT_MAX = max2(max2(T_RCD, T_WR), max2(max2(T_RP, T_RFC), BURST_LEN));
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam int unsigned GAP_W   = $clog2(CNT_MAX + 4) + 1;

  seq_state_e            state, state_n;
  logic [CNT_W-1:0]      cnt, cnt_n;
  sdr_cmd_e              cmd_q, cmd_n;
  logic [SDR_BA_W-1:0]   ba_n;
  logic [SDR_ADDR_W-1:0] addr_n;
  logic                  is_wr;
  logic [COL_W-1:0]      col_l;
  logic                  ref_pending, ref_ack, accept, cnt_zero, rd_slot;

  assign cnt_zero  = (cnt == '0);
  assign req_ready = (state == ST_IDLE) && !ref_pending;
  assign accept    = req_valid && req_ready;
  assign wr_beat   = (state == ST_BURST) && is_wr;
  assign rd_slot   = (state == ST_BURST) && !is_wr;
  assign sd_dq_oe  = wr_beat;
  assign sd_dq_out = wr_beat ? wr_data : '0;
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

  sdr_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk(clk), .rst_n(rst_n), .ack(ref_ack), .pending(ref_pending)
  );

  sdr_read_capture #(.DQ_W(DQ_W), .CAS_LAT(CAS_LAT)) u_cap (
    .clk(clk), .rst_n(rst_n), .rd_slot(rd_slot), .dq_in(sd_dq_in),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always_comb begin
    state_n = state;
    cnt_n   = cnt_zero ? cnt : cnt - 1'b1;
    cmd_n   = CMD_NOP;
    ba_n    = sd_ba;
    addr_n  = sd_addr;
    ref_ack = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (ref_pending) begin
          cmd_n   = CMD_REF;
          ref_ack = 1'b1;
          state_n = ST_REF_WAIT;
          cnt_n   = CNT_W'(phase_load(T_RFC));
        end else if (req_valid) begin
          cmd_n   = CMD_ACT;
          ba_n    = req_bank;
          addr_n  = req_row;
          state_n = ST_ACT_WAIT;
          cnt_n   = CNT_W'(phase_load(T_RCD));
        end
      end
      ST_ACT_WAIT: if (cnt_zero) begin
        cmd_n   = is_wr ? CMD_WR : CMD_RD;
        addr_n  = col_to_addr(SDR_ADDR_W'(col_l));
        state_n = ST_BURST;
        cnt_n   = CNT_W'(phase_load(BURST_LEN));
      end
      ST_BURST: if (cnt_zero) begin
        if (is_wr) begin
          state_n = ST_WR_REC;
          cnt_n   = CNT_W'(phase_load(T_WR));
        end else begin
          cmd_n   = CMD_PRE;
          addr_n  = '0;
          state_n = ST_PRE_WAIT;
          cnt_n   = CNT_W'(phase_load(T_RP));
        end
      end
      ST_WR_REC: if (cnt_zero) begin
        cmd_n   = CMD_PRE;
        addr_n  = '0;
        state_n = ST_PRE_WAIT;
        cnt_n   = CNT_W'(phase_load(T_RP));
      end
      ST_PRE_WAIT, ST_REF_WAIT: if (cnt_zero) state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      cmd_q   <= CMD_NOP;
      sd_ba   <= '0;
      sd_addr <= '0;
      is_wr   <= 1'b0;
      col_l   <= '0;
    end else begin
      state   <= state_n;
      cnt     <= cnt_n;
      cmd_q   <= cmd_n;
      sd_ba   <= ba_n;
      sd_addr <= addr_n;
      if (accept) begin
        is_wr <= req_write;
        col_l <= req_col;
      end
    end
  end

  // Command events and cycle distances, brought out for the assertions.
  logic ev_nop, ev_act, ev_rd, ev_wr, ev_pre, ev_ref;
  assign ev_nop = (cmd_q == CMD_NOP);
  assign ev_act = (cmd_q == CMD_ACT);
  assign ev_rd  = (cmd_q == CMD_RD);
  assign ev_wr  = (cmd_q == CMD_WR);
  assign ev_pre = (cmd_q == CMD_PRE);
  assign ev_ref = (cmd_q == CMD_REF);

  logic [GAP_W-1:0] gap_act, gap_rw, gap_pre, gap_ref, gap_oe;

  function automatic logic [GAP_W-1:0] gap_step(input logic hit, input logic [GAP_W-1:0] g);
    return hit ? '0 : ((g == '1) ? g : g + 1'b1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_act <= '1; gap_rw <= '1; gap_pre <= '1; gap_ref <= '1; gap_oe <= '1;
    end else begin
      gap_act <= gap_step(ev_act, gap_act);
      gap_rw  <= gap_step(ev_rd || ev_wr, gap_rw);
      gap_pre <= gap_step(ev_pre, gap_pre);
      gap_ref <= gap_step(ev_ref, gap_ref);
      gap_oe  <= gap_step(sd_dq_oe, gap_oe);
    end
  end

  AST_RCD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd || ev_wr) |-> (gap_act == GAP_W'(T_RCD - 1))); // R2
  AST_NO_AUTO_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd || ev_wr) |-> !sd_addr[10]); // R2
  AST_OE_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> (ev_wr || (gap_rw < GAP_W'(BURST_LEN - 1)))); // R4
  AST_WR_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pre && is_wr) |-> (gap_oe == GAP_W'(T_WR))); // R5
  AST_RD_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pre && !is_wr) |-> (gap_rw == GAP_W'(BURST_LEN - 1))); // R6
  AST_RP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_act || ev_ref) |-> (gap_pre >= GAP_W'(T_RP))); // R7
  AST_RFC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_nop && !ev_ref) |-> (gap_ref >= GAP_W'(T_RFC))); // R9
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ev_act); // R1
endmodule

// File: tb/tb_sdr_access_seq.sv
`timescale 1ns/1ps
module tb_sdr_access_seq;
  localparam int DQ_W = 16, COL_W = 9, BL = 4, T_RCD = 2, CL = 3;
  localparam int T_WR = 2, T_RP = 2, T_RFC = 6, INT = 150;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101;
  localparam logic [3:0] C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_ready, wr_beat, rd_valid;
  logic [1:0] req_bank = '0;
  logic [12:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [DQ_W-1:0] wr_data = '0, rd_data, sd_dq_out, sd_dq_in = '0;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [1:0] sd_ba;
  logic [12:0] sd_addr;

  always #2 clk = ~clk;

  sdr_access_seq #(.DQ_W(DQ_W), .COL_W(COL_W), .BURST_LEN(BL), .T_RCD(T_RCD),
    .CAS_LAT(CL), .T_WR(T_WR), .T_RP(T_RP), .T_RFC(T_RFC), .REF_INTERVAL(INT)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .wr_data(wr_data), .wr_beat(wr_beat), .rd_data(rd_data), .rd_valid(rd_valid),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
    .sd_dq_in(sd_dq_in));

  typedef struct { int cyc; logic [1:0] ba; logic [12:0] row; logic [COL_W-1:0] col; bit wr; } acc_t;
  typedef struct { logic [DQ_W-1:0] data; int cyc; } item_t;

  acc_t exp_acc[$];
  item_t exp_rd[$], exp_wr[$];
  logic [DQ_W-1:0] wq[$];
  int ref_log[$];
  int cyc = 0, nchk = 0, nfail = 0;
  bit done = 0;

  function automatic logic [DQ_W-1:0] rd_model(logic [1:0] b, logic [12:0] r, logic [COL_W-1:0] c, int k);
    return DQ_W'(16'hA000 ^ (int'(r) * 3 + int'(c) + int'(b) * 77 + k * 257));
  endfunction
  function automatic logic [DQ_W-1:0] wr_model(logic [1:0] b, logic [12:0] r, logic [COL_W-1:0] c, int k);
    return DQ_W'(16'h1000 * k + int'(r) + int'(c) * 5 + int'(b) * 3 + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic finish_test();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // Write-data driver: supplies the next queued word whenever a beat is flagged.
  always @(negedge clk) if (rst_n && wr_beat) wr_data = (wq.size() > 0) ? wq.pop_front() : '0;

  // Request driver: call at a falling edge; returns the accepting cycle.
  task automatic do_access(input bit wr, input logic [1:0] b, input logic [12:0] r,
                           input logic [COL_W-1:0] c, output int acc);
    acc_t a;
    req_write = wr; req_bank = b; req_row = r; req_col = c; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    acc = cyc + 1;
    a.cyc = acc; a.ba = b; a.row = r; a.col = c; a.wr = wr;
    exp_acc.push_back(a);
    for (int k = 0; k < BL; k++) begin
      if (wr) begin
        wq.push_back(wr_model(b, r, c, k));
        exp_wr.push_back('{wr_model(b, r, c, k), acc + T_RCD + k});
      end else exp_rd.push_back('{rd_model(b, r, c, k), acc + T_RCD + CL + 1 + k});
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Memory model and monitor.
  logic [DQ_W-1:0] sched[64];
  bit schedv[64];
  acc_t cur;
  int last_act = -1000, last_rw = -1000, last_pre = -1000, last_ref = -1000, last_oe = -1000;
  initial for (int i = 0; i < 64; i++) schedv[i] = 0;

  always begin
    @(negedge clk); #1;
    if (rst_n) begin : mon
      logic [3:0] cmd;
      item_t it;
      cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (cmd != C_NOP && cmd != C_REF && cyc - last_ref <= T_RFC + 1)
        chk(cyc - last_ref >= T_RFC + 1, "R9", "cmd after refresh gap", cyc - last_ref, T_RFC + 1);
      if ((cmd == C_ACT || cmd == C_REF) && last_pre >= 0)
        chk(cyc - last_pre >= T_RP + 1, "R7", "precharge to next gap", cyc - last_pre, T_RP + 1);
      if (cmd == C_ACT) begin
        if (exp_acc.size() == 0) chk(0, "R1", "unexpected ACTIVE", cyc, -1);
        else begin
          cur = exp_acc.pop_front();
          chk(cyc == cur.cyc, "R1", "ACTIVE cycle", cyc, cur.cyc);
          chk(sd_ba == cur.ba, "R1", "ACTIVE bank", sd_ba, cur.ba);
          chk(sd_addr == cur.row, "R1", "ACTIVE row", sd_addr, cur.row);
        end
        last_act = cyc;
      end else if (cmd == C_RD || cmd == C_WR) begin
        chk(cmd == (cur.wr ? C_WR : C_RD), "R2", "column command", cmd, cur.wr ? C_WR : C_RD);
        chk(cyc == last_act + T_RCD, "R2", "column cmd cycle", cyc, last_act + T_RCD);
        chk(sd_addr == 13'(cur.col), "R2", "column addr (A10 low)", sd_addr, cur.col);
        chk(sd_ba == cur.ba, "R2", "column bank", sd_ba, cur.ba);
        last_rw = cyc;
        if (cmd == C_RD)
          for (int k = 0; k < BL; k++) begin
            sched[(cyc + CL + k) % 64] = rd_model(cur.ba, cur.row, cur.col, k);
            schedv[(cyc + CL + k) % 64] = 1;
          end
      end else if (cmd == C_PRE) begin
        if (cur.wr) chk(cyc == last_oe + T_WR + 1, "R5", "write precharge cycle", cyc, last_oe + T_WR + 1);
        else        chk(cyc == last_rw + BL, "R6", "read precharge cycle", cyc, last_rw + BL);
        chk(!sd_addr[10] && sd_ba == cur.ba, "R6", "precharge single bank", {sd_addr[10], sd_ba}, cur.ba);
        last_pre = cyc;
      end else if (cmd == C_REF) begin
        ref_log.push_back(cyc);
        last_ref = cyc;
      end
      chk(wr_beat == sd_dq_oe, "R4", "wr_beat matches oe", wr_beat, sd_dq_oe);
      if (sd_dq_oe) begin
        if (exp_wr.size() == 0) chk(0, "R4", "unexpected write beat", cyc, -1);
        else begin
          it = exp_wr.pop_front();
          chk(cyc == it.cyc, "R4", "write beat cycle", cyc, it.cyc);
          chk(sd_dq_out == it.data, "R4", "write word", sd_dq_out, it.data);
        end
        last_oe = cyc;
      end
      if (rd_valid) begin
        if (exp_rd.size() == 0) chk(0, "R3", "unexpected rd_valid", cyc, -1);
        else begin
          it = exp_rd.pop_front();
          chk(cyc == it.cyc, "R3", "read word cycle", cyc, it.cyc);
          chk(rd_data == it.data, "R3", "read word", rd_data, it.data);
        end
      end
      sd_dq_in = schedv[cyc % 64] ? sched[cyc % 64] : 16'hDEAD;
      schedv[cyc % 64] = 0;
    end
  end

  initial begin
    #80000;
    chk(0, "R1", "watchdog expired", cyc, -1);
    finish_test();
  end

  initial begin
    int acc;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R10", "cmd after reset", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
    chk(!sd_dq_oe && !rd_valid, "R10", "oe/rd_valid after reset", {sd_dq_oe, rd_valid}, 0);
    chk(req_ready, "R10", "ready after reset", req_ready, 1);
    // R8: first refresh on an idle sequencer
    wait (ref_log.size() > 0);
    chk(ref_log[0] == INT + 1, "R8", "first refresh cycle", ref_log[0], INT + 1);
    @(negedge clk);
    do_access(1, 2'd1, 13'h0123, 9'h010, acc);
    do_access(0, 2'd1, 13'h0123, 9'h010, acc);
    do_access(0, 2'd3, 13'h1FFF, 9'h1FF, acc);
    do_access(1, 2'd0, 13'h0000, 9'h000, acc);
    do_access(1, 2'd2, 13'h0AAA, 9'h155, acc);
    do_access(0, 2'd2, 13'h0555, 9'h0AA, acc);
    do_access(0, 2'd0, 13'h1000, 9'h001, acc);
    do_access(1, 2'd3, 13'h1FFF, 9'h1FE, acc);
    // R9: request raised just as a refresh demand appears
    while (cyc < 3 * INT) @(negedge clk);
    chk(!req_ready, "R9", "ready low while refresh pending", req_ready, 0);
    do_access(0, 2'd1, 13'h0777, 9'h033, acc);
    chk(acc == 3 * INT + T_RFC + 2, "R9", "ACTIVE after refresh", acc, 3 * INT + T_RFC + 2);
    repeat (30) @(negedge clk);
    chk(ref_log.size() == 3, "R8", "refresh count", ref_log.size(), 3);
    for (int i = 0; i < ref_log.size() && i < 3; i++)
      chk(ref_log[i] == (i + 1) * INT + 1, "R8", "refresh cycle", ref_log[i], (i + 1) * INT + 1);
    chk(exp_acc.size() == 0 && exp_rd.size() == 0 && exp_wr.size() == 0, "R3",
        "all expected events seen", exp_acc.size() + exp_rd.size() + exp_wr.size(), 0);
    finish_test();
  end
endmodule